// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of every line in one private, direct-mapped cache that sits on a shared snooping bus. It decides whether a local read or write can finish at once. When it cannot, it requests the bus transaction the access needs. It also watches transactions that other caches place on the bus and answers them: it reports whether it holds the line, and whether it must supply the data itself.

Five states are tracked: Modified, Owned, Exclusive, Shared and Invalid. In the Owned state a dirty line can be shared with other caches, and the owning cache, not memory, supplies data to other caches' reads. Data storage and bus arbitration lie outside the block. The bus appears as a request/grant handshake and a shared-response input. All addresses at the ports are line addresses, split into a set index (low bits) and a tag (high bits).

A local request is held steady until `cpu_done`. Grant and snoop never arrive in the same cycle. The line-state encoding is visible on `cpu_state`, which shows the stored state of the set addressed by `cpu_addr` when its tag matches, and Invalid otherwise.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid; `cpu_state` reads 0 and `cpu_hit` is low for any address. State codes: Invalid 0, Shared 1, Exclusive 2, Owned 3, Modified 4.
- R2: A read whose line is not present issues bus op Read (code 1) with the requested line address; in the grant cycle `cpu_done` rises and the line fills Exclusive if `bus_shared` is low, Shared if high.
- R3: A read to a present line in any valid state completes in the same cycle with no bus request.
- R4: A write to a present line in Modified or Exclusive completes in the same cycle with no bus request; Exclusive becomes Modified.
- R5: A write to a present line in Shared or Owned issues bus op Invalidate (code 3); on grant it completes and the line becomes Modified.
- R6: A write whose line is not present issues bus op Read-for-ownership (code 2); on grant it completes and the line becomes Modified.
- R7: When a miss would replace a Modified or Owned line, a Writeback op (code 4) with the victim's line address is issued first without completing the access; on grant the victim becomes Invalid. A victim in Exclusive, Shared or Invalid is replaced directly by the fill, with no Writeback.
- R8: A snooped Read that hits asserts `snp_hit` and `snp_shared`. A Modified line moves to Owned and an Owned line stays Owned, both asserting `snp_supply`. Exclusive moves to Shared and Shared stays Shared, without supply.
- R9: A snooped Read-for-ownership that hits moves the line to Invalid and asserts `snp_supply` only if the line was Modified or Owned.
- R10: A snooped Invalidate that hits moves the line to Invalid without supply. A snooped Writeback, or any snoop whose tag differs from the stored one, changes nothing.
- R11: While a snoop targets the same set as a local request, the local request does not complete in that cycle; the snoop's state change is applied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Local access request, held until done |
| cpu_we | input | 1 | Local access is a write |
| cpu_addr | input | ADDR_W | Local line address |
| cpu_hit | output | 1 | Addressed line is present in a valid state |
| cpu_done | output | 1 | Local access completes this cycle |
| cpu_state | output | 3 | State code of the addressed line |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 3 | Requested bus op code |
| bus_addr | output | ADDR_W | Line address of the requested transaction |
| bus_gnt | input | 1 | Grant for the requested transaction |
| bus_shared | input | 1 | Another cache holds the line (valid with grant) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 3 | Snooped op code |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_hit | output | 1 | Snooped line present here |
| snp_supply | output | 1 | This cache supplies the snooped data |
| snp_shared | output | 1 | Shared response for a snooped Read |

## Verification
The bench builds the block with ADDR_W=8 and IDX_W=2: four sets and six tag bits. With four sets, two tags that map to the same set force a replacement within a few accesses. This brings both the dirty-victim path (Writeback first, then the fill) and the clean-victim path (fill directly) into a short directed run. The small tag also makes it cheap to aim a snoop at an occupied set with a different tag, to show that it has no effect. Every state transition is observed on `cpu_state` by probing the address afterwards.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_INV = 3'd0,
        ST_SHR = 3'd1,
        ST_EXC = 3'd2,
        ST_OWN = 3'd3,
        ST_MOD = 3'd4
    } line_st_t;

    typedef enum logic [2:0] {
        BOP_NONE  = 3'd0,
        BOP_READ  = 3'd1,
        BOP_READX = 3'd2,
        BOP_INVAL = 3'd3,
        BOP_WBACK = 3'd4
    } bus_op_t;

    typedef struct packed {
        logic hit;
        logic supply;
        logic shared;
    } snp_resp_t;

    function automatic logic st_dirty(line_st_t s);
        return (s == ST_MOD) || (s == ST_OWN);
    endfunction

    function automatic logic st_writable(line_st_t s);
        return (s == ST_MOD) || (s == ST_EXC);
    endfunction

    // state a line takes after another cache's transaction hits it
    function automatic line_st_t snoop_next(line_st_t s, bus_op_t op);
        line_st_t n;
        n = s;
        case (op)
            BOP_READ: begin
                if (s == ST_MOD)      n = ST_OWN;
                else if (s == ST_EXC) n = ST_SHR;
            end
            BOP_READX, BOP_INVAL: n = ST_INV;
            default: n = s;
        endcase
        return n;
    endfunction

    // state the addressed line takes when our own transaction is granted
    function automatic line_st_t grant_next(bus_op_t op, logic shared);
        line_st_t n;
        case (op)
            BOP_READ:             n = shared ? ST_SHR : ST_EXC;
            BOP_READX, BOP_INVAL: n = ST_MOD;
            default:              n = ST_INV;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/moesi_tag_store.sv
module moesi_tag_store
    import moesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output line_st_t         a_st,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output line_st_t         b_st,
    input  logic             l_we,
    input  logic [IDX_W-1:0] l_idx,
    input  logic [TAG_W-1:0] l_tag,
    input  line_st_t         l_st,
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_idx,
    input  line_st_t         s_st
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    line_st_t         st_q  [SETS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SETS; i++) begin
            if (rst) begin
                st_q[i]  <= ST_INV;
                tag_q[i] <= '0;
            end else if (s_we && (s_idx == IDX_W'(i))) begin
                st_q[i] <= s_st;
            end else if (l_we && (l_idx == IDX_W'(i))) begin
                st_q[i]  <= l_st;
                tag_q[i] <= l_tag;
            end
        end
    end

    assign a_tag = tag_q[a_idx];
    assign a_st  = st_q[a_idx];
    assign b_tag = tag_q[b_idx];
    assign b_st  = st_q[b_idx];

    AST_WRITE_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        !(l_we && s_we && (l_idx == s_idx))); // R11

    for (genvar g = 0; g < SETS; g++) begin : g_legal
        AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
            st_q[g] inside {ST_INV, ST_SHR, ST_EXC, ST_OWN, ST_MOD}); // R1
    end

endmodule

// File: rtl/moesi_local_ctl.sv
module moesi_local_ctl
    import moesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [TAG_W-1:0] cpu_tag,
    input  logic [TAG_W-1:0] lk_tag,
    input  line_st_t         lk_st,
    input  logic             snp_block,
    input  logic             bus_gnt,
    input  logic             bus_shared,
    output logic             tag_hit,
    output logic             cpu_done,
    output logic             bus_req,
    output bus_op_t          bus_op,
    output logic [TAG_W-1:0] bus_tag,
    output logic             l_we,
    output logic [TAG_W-1:0] l_tag,
    output line_st_t         l_st
);
    bus_op_t op_c;
    logic    local_ok;
    logic    granted;

    always_comb begin
        tag_hit  = (lk_st != ST_INV) && (lk_tag == cpu_tag);
        local_ok = cpu_req && tag_hit && (!cpu_we || st_writable(lk_st)) && !snp_block;

        if (tag_hit)
            op_c = (cpu_we && !st_writable(lk_st)) ? BOP_INVAL : BOP_NONE;
        else if (st_dirty(lk_st))
            op_c = BOP_WBACK;
        else
            op_c = cpu_we ? BOP_READX : BOP_READ;

        bus_req  = cpu_req && (op_c != BOP_NONE);
        bus_op   = cpu_req ? op_c : BOP_NONE;
        bus_tag  = (op_c == BOP_WBACK) ? lk_tag : cpu_tag;
        granted  = bus_req && bus_gnt;

        l_we     = granted || (local_ok && cpu_we && (lk_st == ST_EXC));
        l_st     = granted ? grant_next(op_c, bus_shared) : ST_MOD;
        l_tag    = bus_tag;
        cpu_done = local_ok || (granted && (op_c != BOP_WBACK));
    end

    AST_EXCL_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        cpu_req && cpu_we && tag_hit && st_writable(lk_st) && !snp_block
        |-> cpu_done && !bus_req); // R4

    AST_FILL_FOLLOWS_SHARED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(granted && (op_c == BOP_READ)) && ($past(cpu_idx) == cpu_idx)
        |-> lk_st == ($past(bus_shared) ? ST_SHR : ST_EXC)); // R2

    AST_VICTIM_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(granted && (op_c == BOP_WBACK)) && ($past(cpu_idx) == cpu_idx)
        |-> lk_st == ST_INV); // R7

    AST_SNOOP_STALLS_LOCAL: assert property (@(posedge clk) disable iff (rst)
        snp_block && !bus_gnt |-> !cpu_done); // R11

endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
    import moesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid,
    input  bus_op_t          snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] s_lk_tag,
    input  line_st_t         s_lk_st,
    output snp_resp_t        resp,
    output logic             s_we,
    output line_st_t         s_st
);
    logic     hit;
    line_st_t nxt;

    always_comb begin
        hit         = snp_valid && (s_lk_st != ST_INV) && (s_lk_tag == snp_tag);
        nxt         = snoop_next(s_lk_st, snp_op);
        resp.hit    = hit;
        resp.supply = hit && st_dirty(s_lk_st) &&
                      ((snp_op == BOP_READ) || (snp_op == BOP_READX));
        resp.shared = hit && (snp_op == BOP_READ);
        s_we        = hit && (nxt != s_lk_st);
        s_st        = nxt;
    end

    AST_SNP_READ_M_TO_O: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(hit && (snp_op == BOP_READ) && (s_lk_st == ST_MOD))
        && ($past(snp_idx) == snp_idx) |-> s_lk_st == ST_OWN); // R8

    AST_SNP_KILLS_LINE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(hit && ((snp_op == BOP_READX) || (snp_op == BOP_INVAL)))
        && ($past(snp_idx) == snp_idx) |-> s_lk_st == ST_INV); // R9

    AST_SUPPLY_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
        snp_valid && !st_dirty(s_lk_st) |-> !resp.supply); // R8

endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
    import moesi_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_hit,
    output logic              cpu_done,
    output logic [2:0]        cpu_state,
    output logic              bus_req,
    output logic [2:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [2:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic              snp_supply,
    output logic              snp_shared
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    logic [TAG_W-1:0] a_tag, b_tag, l_tag, bus_tag;
    line_st_t         a_st, b_st, l_st, s_st;
    logic             l_we, s_we, tag_hit, snp_block;
    bus_op_t          op_t;
    snp_resp_t        resp;

    assign cpu_idx   = cpu_addr[IDX_W-1:0];
    assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[ADDR_W-1:IDX_W];
    assign snp_block = snp_valid && (snp_idx == cpu_idx);

    moesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .a_idx(cpu_idx), .a_tag(a_tag), .a_st(a_st),
        .b_idx(snp_idx), .b_tag(b_tag), .b_st(b_st),
        .l_we(l_we), .l_idx(cpu_idx), .l_tag(l_tag), .l_st(l_st),
        .s_we(s_we), .s_idx(snp_idx), .s_st(s_st)
    );

    moesi_local_ctl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_local (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
        .lk_tag(a_tag), .lk_st(a_st), .snp_block(snp_block),
        .bus_gnt(bus_gnt), .bus_shared(bus_shared),
        .tag_hit(tag_hit), .cpu_done(cpu_done), .bus_req(bus_req),
        .bus_op(op_t), .bus_tag(bus_tag),
        .l_we(l_we), .l_tag(l_tag), .l_st(l_st)
    );

    moesi_snoop_resp #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_op(bus_op_t'(snp_op)),
        .snp_idx(snp_idx), .snp_tag(snp_tag),
        .s_lk_tag(b_tag), .s_lk_st(b_st),
        .resp(resp), .s_we(s_we), .s_st(s_st)
    );

    assign cpu_hit    = tag_hit;
    assign cpu_state  = tag_hit ? 3'(a_st) : 3'(ST_INV);
    assign bus_op     = 3'(op_t);
    assign bus_addr   = {bus_tag, cpu_idx};
    assign snp_hit    = resp.hit;
    assign snp_supply = resp.supply;
    assign snp_shared = resp.shared;

    AST_GRANT_NOT_DURING_SNOOP: assert property (@(posedge clk) disable iff (rst)
        !(bus_gnt && snp_valid)); // R11

    AST_GRANT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        cpu_done && !tag_hit |-> bus_req && bus_gnt); // R2

endmodule

// File: tb/sim_moesi_ctrl.sv
module sim_moesi_ctrl;
    localparam int AW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_hit, cpu_done;
    logic [2:0]    cpu_state;
    logic          bus_req;
    logic [2:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt = 0, bus_shared = 0;
    logic          snp_valid = 0;
    logic [2:0]    snp_op = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_hit, snp_supply, snp_shared;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    moesi_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_hit(cpu_hit), .cpu_done(cpu_done), .cpu_state(cpu_state),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_hit(snp_hit), .snp_supply(snp_supply), .snp_shared(snp_shared)
    );

    // state codes and op codes from the requirements
    localparam int S_I = 0, S_S = 1, S_E = 2, S_O = 3, S_M = 4;
    localparam int O_RD = 1, O_RDX = 2, O_INV = 3, O_WB = 4;

    function automatic logic [AW-1:0] la(input int tag, input int idx);
        return AW'((tag << IW) | idx);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input logic [AW-1:0] a, input int exp);
        cpu_req  = 0;
        cpu_addr = a;
        #1;
        chk(req, cpu_state, exp);
    endtask

    task automatic hit_access(input string req, input logic we, input logic [AW-1:0] a);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a;
        #1;
        chk({req, " done"}, cpu_done, 1);
        chk({req, " no bus"}, bus_req, 0);
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic bus_access(input string req, input logic we, input logic [AW-1:0] a,
                              input logic sh, input int exp_op,
                              input logic [AW-1:0] exp_addr, input int exp_done);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a;
        #1;
        chk({req, " bus_req"}, bus_req, 1);
        chk({req, " bus_op"}, bus_op, exp_op);
        chk({req, " bus_addr"}, bus_addr, exp_addr);
        chk({req, " not done before grant"}, cpu_done, 0);
        bus_gnt = 1; bus_shared = sh;
        #1;
        chk({req, " done at grant"}, cpu_done, exp_done);
        @(negedge clk);
        bus_gnt = 0; bus_shared = 0; cpu_req = 0; cpu_we = 0;
    endtask

    task automatic snoop(input string req, input int op, input logic [AW-1:0] a,
                         input int e_hit, input int e_sup, input int e_sh);
        @(negedge clk);
        snp_valid = 1; snp_op = 3'(op); snp_addr = a;
        #1;
        chk({req, " snp_hit"}, snp_hit, e_hit);
        chk({req, " snp_supply"}, snp_supply, e_sup);
        chk({req, " snp_shared"}, snp_shared, e_sh);
        @(negedge clk);
        snp_valid = 0; snp_op = '0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            expect_state("R1 reset state", la(0, i), S_I);
            chk("R1 reset miss", cpu_hit, 0);
        end
    endtask

    task automatic t_exclusive_path;
        bus_access("R2 read miss alone", 0, la(1, 0), 0, O_RD, la(1, 0), 1);
        expect_state("R2 fill Exclusive", la(1, 0), S_E);
        hit_access("R3 read hit E", 0, la(1, 0));
        hit_access("R4 write hit E", 1, la(1, 0));
        expect_state("R4 E becomes M", la(1, 0), S_M);
        hit_access("R4 write hit M", 1, la(1, 0));
        expect_state("R4 M stays M", la(1, 0), S_M);
    endtask

    task automatic t_owner_path;
        snoop("R8 snoop read on M", O_RD, la(1, 0), 1, 1, 1);
        expect_state("R8 M becomes O", la(1, 0), S_O);
        snoop("R8 snoop read on O", O_RD, la(1, 0), 1, 1, 1);
        expect_state("R8 O stays O", la(1, 0), S_O);
        hit_access("R3 read hit O", 0, la(1, 0));
        bus_access("R5 write on O", 1, la(1, 0), 0, O_INV, la(1, 0), 1);
        expect_state("R5 O becomes M", la(1, 0), S_M);
    endtask

    task automatic t_shared_path;
        bus_access("R2 read miss shared", 0, la(1, 1), 1, O_RD, la(1, 1), 1);
        expect_state("R2 fill Shared", la(1, 1), S_S);
        snoop("R8 snoop read on S", O_RD, la(1, 1), 1, 0, 1);
        expect_state("R8 S stays S", la(1, 1), S_S);
        bus_access("R5 write on S", 1, la(1, 1), 0, O_INV, la(1, 1), 1);
        expect_state("R5 S becomes M", la(1, 1), S_M);
    endtask

    task automatic t_evictions;
        // set 0 holds tag 1 in M: writeback first
        bus_access("R7 dirty victim", 0, la(2, 0), 0, O_WB, la(1, 0), 0);
        expect_state("R7 victim invalid", la(1, 0), S_I);
        bus_access("R7 fill after wb", 0, la(2, 0), 0, O_RD, la(2, 0), 1);
        expect_state("R7 new line E", la(2, 0), S_E);
        // clean victim: direct fill
        bus_access("R7 clean victim", 0, la(3, 0), 0, O_RD, la(3, 0), 1);
        expect_state("R7 replaced line", la(3, 0), S_E);
        expect_state("R7 old tag gone", la(2, 0), S_I);
    endtask

    task automatic t_ownership;
        snoop("R9 snoop rfo on E", O_RDX, la(3, 0), 1, 0, 0);
        expect_state("R9 E invalidated", la(3, 0), S_I);
        bus_access("R6 write miss", 1, la(1, 2), 0, O_RDX, la(1, 2), 1);
        expect_state("R6 fill Modified", la(1, 2), S_M);
        snoop("R9 snoop rfo on M", O_RDX, la(1, 2), 1, 1, 0);
        expect_state("R9 M invalidated", la(1, 2), S_I);
    endtask

    task automatic t_ignored_snoops;
        bus_access("R2 read miss set3", 0, la(1, 3), 1, O_RD, la(1, 3), 1);
        hit_access("R3 read hit S", 0, la(1, 3));
        snoop("R10 snoop wback", O_WB, la(1, 3), 1, 0, 0);
        expect_state("R10 wback no effect", la(1, 3), S_S);
        snoop("R10 other tag", O_RDX, la(5, 3), 0, 0, 0);
        expect_state("R10 other tag no effect", la(1, 3), S_S);
        snoop("R10 snoop inval", O_INV, la(1, 3), 1, 0, 0);
        expect_state("R10 inval to I", la(1, 3), S_I);
    endtask

    task automatic t_stall;
        // set 1 holds tag 1 in M
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = la(1, 1);
        snp_valid = 1; snp_op = 3'(O_RD); snp_addr = la(1, 1);
        #1;
        chk("R11 stalled by snoop", cpu_done, 0);
        chk("R11 snoop supplies", snp_supply, 1);
        @(negedge clk);
        snp_valid = 0; snp_op = '0;
        #1;
        chk("R11 completes after snoop", cpu_done, 1);
        chk("R11 line now O", cpu_state, S_O);
        @(negedge clk);
        cpu_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_exclusive_path();
        t_owner_path();
        t_shared_path();
        t_evictions();
        t_ownership();
        t_ignored_snoops();
        t_stall();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule